// File: doc/BRIEF.md
# Compare Output Waveform Generator for a Channel Pair

This block produces the two output levels of a pair of adjacent compare channels in a 16-bit timer. It does not count or compare. It receives single-cycle event pulses from outside: one compare-match pulse per channel, plus counter MAX and ZERO pulses. From these pulses it sets, clears or toggles a registered output level for each channel. The event that re-activates an output depends on the count direction. In up counting it is MAX. In up/down counting and in down counting it is ZERO.

Each channel has its own 3-bit output mode, a pair-mode bit, a software level bit and a capture-mode bit. With the pair-mode bit clear, a channel uses only its own match together with MAX or ZERO. With the pair-mode bit set, a channel uses both matches of the pair, and the two channels take complementary roles. When a channel is in capture mode, its output configuration is ignored and its output keeps its level.

Top module: `pwm_pair_outgen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both outputs go low (low is the inactive level).
- R2: Output mode 0 (software): after each edge the output equals that channel's `sw_level` bit.
- R3: Mode 7, pair bit clear: the channel's own match clears the output. MAX sets it when `cnt_dir` is 0 (up). ZERO sets it when `cnt_dir` is 1 (up/down), 2 (down) or 3 (handled like down).
- R4: Mode 7, pair bit set: channel 0 is cleared by match 0 and set by match 1. Channel 1 is cleared by match 1 and set by match 0. MAX and ZERO have no effect.
- R5: Mode 6, pair bit clear: the own match inverts the output. MAX or ZERO sets it, chosen by the same direction rule as R3.
- R6: Mode 6, pair bit set: the own match inverts the output and the partner's match sets it.
- R7: Mode 5: the own match clears the output. With the pair bit set, either match of the pair clears it. The output is never set, in any count direction.
- R8: Mode codes 1 to 4 hold the output at its present level.
- R9: While a channel's `cap_mode` bit is 1, its output holds its level whatever its mode, pair and software bits are.
- R10: A clear and a set in the same cycle leave the output low. A toggle and a set in the same cycle leave it high.
- R11: Outputs are registered. Each output reflects the events and configuration of the previous rising edge, and is otherwise stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_dir | input | 2 | Count direction: 0 up, 1 up/down, 2 down, 3 treated as down |
| max_evt | input | 1 | Counter reached MAX (one-cycle pulse) |
| zero_evt | input | 1 | Counter reached ZERO (one-cycle pulse) |
| match_evt | input | 2 | Compare-match pulse; bit i is channel i |
| cap_mode | input | 2 | Bit i = 1: channel i is in capture mode |
| out_mode | input | 6 | Output mode; bits [3i+2:3i] are channel i |
| pair_mode | input | 2 | Bit i = 1: channel i uses both matches |
| sw_level | input | 2 | Software output level for mode 0 |
| tout | output | 2 | Output level; bit i is channel i |

## Verification
Several events can arrive in the same cycle. A channel's own match can coincide with the reactivating MAX or ZERO pulse. Both matches of a pair can fire together, which gives clear-versus-set in mode 7 and toggle-versus-set in mode 6. Directed steps raise these pulses together in one cycle. Long random runs also raise them together often, with every mode, direction and pair setting. After every edge, each output is compared with a behavioural model that applies the priority rule of R10.

// File: rtl/outgen_pkg.sv
// Shared definitions for the compare output waveform generator.
// Assumes that the channel count of a pair is fixed at two.
package outgen_pkg;
    localparam int NCH   = 2;
    localparam int MODEW = 3;

    typedef enum logic [1:0] {
        DIR_UP   = 2'd0,
        DIR_UPDN = 2'd1,
        DIR_DOWN = 2'd2,
        DIR_RSVD = 2'd3
    } cnt_dir_e;

    typedef enum logic [MODEW-1:0] {
        OM_SOFT   = 3'd0,
        OM_CLRONLY = 3'd5,
        OM_TGLSET = 3'd6,
        OM_CLRSET = 3'd7
    } out_mode_e;

    typedef struct packed {
        logic set_evt;
        logic clr_own;
        logic clr_any;
        logic tgl_evt;
    } chan_evt_t;
endpackage

// File: rtl/outgen_evt_sel.sv
// Event routing for one channel. Turns the raw pulses into set, clear and
// toggle requests according to the pair bit and the count direction.
// Assumes that all inputs are single-cycle pulses that are synchronous to the clock.
module outgen_evt_sel
    import outgen_pkg::*;
(
    input  logic      own_match,
    input  logic      peer_match,
    input  logic      max_evt,
    input  logic      zero_evt,
    input  logic      pair,
    input  cnt_dir_e  dir,
    output chan_evt_t evt
);
    logic rearm;

    // Pick the counter event that re-activates the output.
    always_comb begin
        rearm = (dir == DIR_UP) ? max_evt : zero_evt;
    end

    // Form the requests for this channel.
    always_comb begin
        evt.set_evt = pair ? peer_match : rearm;
        evt.clr_own = own_match;
        evt.clr_any = own_match | (pair & peer_match);
        evt.tgl_evt = own_match;
    end
endmodule

// File: rtl/outgen_chan.sv
// Output state register for one channel. Applies the mode decoding, with
// the priorities clear over set and set over toggle.
// Assumes a synchronous active-low reset, and that low is the inactive level.
module outgen_chan
    import outgen_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic [MODEW-1:0]       mode,
    input  logic                   sw_lvl,
    input  chan_evt_t              evt,
    output logic                   q
);
    logic q_nxt;

    // Compute the next output level from the mode and the requests.
    always_comb begin
        q_nxt = q;
        if (!capture) begin
            unique case (mode)
                OM_SOFT:    q_nxt = sw_lvl;
                OM_CLRSET:  q_nxt = evt.clr_own ? 1'b0 : (evt.set_evt ? 1'b1 : q);
                OM_TGLSET:  q_nxt = evt.set_evt ? 1'b1 : (evt.tgl_evt ? ~q : q);
                OM_CLRONLY: q_nxt = evt.clr_any ? 1'b0 : q;
                default:    q_nxt = q;
            endcase
        end
    end

    // Register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_nxt;
    end
endmodule

// File: rtl/pwm_pair_outgen.sv
// Top level: generates two channels, each with its own event router and state register.
// Channel i takes channel (NCH-1-i) as its pair partner.
// Assumes that the counter and the comparators are outside this block.
module pwm_pair_outgen
    import outgen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cnt_dir,
    input  logic                 max_evt,
    input  logic                 zero_evt,
    input  logic [NCH-1:0]       match_evt,
    input  logic [NCH-1:0]       cap_mode,
    input  logic [NCH*MODEW-1:0] out_mode,
    input  logic [NCH-1:0]       pair_mode,
    input  logic [NCH-1:0]       sw_level,
    output logic [NCH-1:0]       tout
);
    cnt_dir_e dir;
    assign dir = cnt_dir_e'(cnt_dir);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int PEER = NCH - 1 - i;
        chan_evt_t evt;

        outgen_evt_sel u_sel (
            .own_match (match_evt[i]),
            .peer_match(match_evt[PEER]),
            .max_evt   (max_evt),
            .zero_evt  (zero_evt),
            .pair      (pair_mode[i]),
            .dir       (dir),
            .evt       (evt)
        );

        outgen_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .capture(cap_mode[i]),
            .mode   (out_mode[i*MODEW +: MODEW]),
            .sw_lvl (sw_level[i]),
            .evt    (evt),
            .q      (tout[i])
        );
    end
endmodule

// File: rtl/pwm_pair_outgen_chk.sv
// Checker for pwm_pair_outgen. It observes only the ports of the top module.
// It is attached to the top module with the bind statement at the end of this file.
module pwm_pair_outgen_chk
    import outgen_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       match_evt,
    input logic [NCH-1:0]       cap_mode,
    input logic [NCH*MODEW-1:0] out_mode,
    input logic [NCH-1:0]       pair_mode,
    input logic [NCH-1:0]       sw_level,
    input logic [NCH-1:0]       tout
);
    logic seen_edge;

    // Mark the first clock edge, so that no check looks at values from before it.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // R1
    reset_low_chk: assert property (@(posedge clk)
        seen_edge && $past(!rst_n) |-> tout == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R2
        sw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seen_edge && $past(rst_n) && $past(!cap_mode[i]) &&
            $past(out_mode[i*MODEW +: MODEW]) == 3'd0
            |-> tout[i] == $past(sw_level[i]));

        // R10
        clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seen_edge && $past(rst_n) && $past(!cap_mode[i]) &&
            $past(out_mode[i*MODEW +: MODEW]) == 3'd7 && $past(match_evt[i])
            |-> !tout[i]);

        // R7
        no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seen_edge && $past(rst_n) && $past(!cap_mode[i]) &&
            $past(out_mode[i*MODEW +: MODEW]) == 3'd5
            |-> !$rose(tout[i]));

        // R9
        cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seen_edge && $past(rst_n) && $past(cap_mode[i])
            |-> $stable(tout[i]));

        // R6
        tgl_pair_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seen_edge && $past(rst_n) && $past(!cap_mode[i]) && $past(pair_mode[i]) &&
            $past(out_mode[i*MODEW +: MODEW]) == 3'd6 && $past(match_evt[NCH-1-i])
            |-> tout[i]);
    end
endmodule

bind pwm_pair_outgen pwm_pair_outgen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .match_evt(match_evt),
    .cap_mode (cap_mode),
    .out_mode (out_mode),
    .pair_mode(pair_mode),
    .sw_level (sw_level),
    .tout     (tout)
);

// File: tb/pwm_pair_outgen_test.sv
module pwm_pair_outgen_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cnt_dir = '0;
    logic       max_evt = 1'b0, zero_evt = 1'b0;
    logic [1:0] match_evt = '0, cap_mode = '0, pair_mode = '0, sw_level = '0;
    logic [5:0] out_mode = '0;
    logic [1:0] tout;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    bit exp_q [2];
    string last_req [2];

    pwm_pair_outgen uut (
        .clk(clk), .rst_n(rst_n), .cnt_dir(cnt_dir), .max_evt(max_evt),
        .zero_evt(zero_evt), .match_evt(match_evt), .cap_mode(cap_mode),
        .out_mode(out_mode), .pair_mode(pair_mode), .sw_level(sw_level),
        .tout(tout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model of one channel, derived from the requirements.
    function automatic bit model(bit q, int md, bit pr, bit sw, bit cap,
                                 bit own, bit oth, bit mx, bit zr, int dir,
                                 output string req);
        bit rearm = (dir == 0) ? mx : zr;
        req = "R11";
        if (cap) begin req = "R9"; return q; end
        if (md == 0) begin req = "R2"; return sw; end
        if (md == 7) begin
            req = pr ? "R4" : "R3";
            if (own && (pr ? oth : rearm)) req = "R10";
            if (own) return 0;
            if (pr ? oth : rearm) return 1;
            return q;
        end
        if (md == 6) begin
            req = pr ? "R6" : "R5";
            if (own && (pr ? oth : rearm)) req = "R10";
            if (pr ? oth : rearm) return 1;
            return own ? !q : q;
        end
        if (md == 5) begin
            req = "R7";
            return (own || (pr && oth)) ? 0 : q;
        end
        req = "R8";
        return q;
    endfunction

    // Advance the model on every edge, from the inputs held over that edge.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            string r;
            if (!rst_n) begin exp_q[i] = 0; last_req[i] = "R1"; end
            else begin
                exp_q[i] = model(exp_q[i], int'(out_mode[i*3 +: 3]), pair_mode[i],
                                 sw_level[i], cap_mode[i], match_evt[i],
                                 match_evt[1-i], max_evt, zero_evt, int'(cnt_dir), r);
                last_req[i] = r;
            end
        end
    end

    // Compare after the edge, away from it.
    task automatic compare();
        for (int i = 0; i < 2; i++) begin
            n_chk++;
            if (tout[i] !== exp_q[i]) begin
                n_bad++;
                $display("FAIL %s ch%0d: tout=%b expected=%b at %0t",
                         last_req[i], i, tout[i], exp_q[i], $time);
            end
        end
    endtask

    // One cycle: drive at the falling edge, and check at the next falling edge.
    task automatic step(input logic [1:0] m, input logic mx, input logic zr);
        match_evt = m; max_evt = mx; zero_evt = zr;
        @(negedge clk);
        compare();
        match_evt = '0; max_evt = 0; zero_evt = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset, with every event active
        out_mode = 6'o00; sw_level = 2'b11;
        @(negedge clk);
        step(2'b11, 1, 1);
        rst_n = 1;
        // R2: software level
        step(0, 0, 0);
        sw_level = 2'b01; step(0, 0, 0);
        // R3: mode 7 single, up count: the set comes from MAX
        out_mode = {3'd7, 3'd7}; pair_mode = 0; cnt_dir = 0;
        step(2'b01, 0, 0); step(0, 0, 1); step(0, 1, 0);
        step(2'b11, 0, 0); cnt_dir = 2; step(0, 1, 0); step(0, 0, 1);
        cnt_dir = 3; step(2'b11, 0, 0); step(0, 0, 1);
        // R10: clear together with set
        cnt_dir = 0; step(2'b01, 1, 0);
        // R4: mode 7 pair
        pair_mode = 2'b11; step(2'b10, 0, 0); step(2'b01, 1, 1); step(2'b11, 0, 0);
        // R6 and R10: mode 6 pair, both matches together
        out_mode = {3'd6, 3'd6}; step(2'b11, 0, 0); step(2'b11, 0, 0);
        // R5: mode 6 single, toggle
        pair_mode = 0; cnt_dir = 1; step(2'b01, 0, 0); step(2'b01, 0, 0); step(2'b10, 0, 1);
        // R7: mode 5
        out_mode = {3'd5, 3'd5}; pair_mode = 2'b10; step(2'b01, 1, 1); step(0, 1, 1);
        // R8 and R9
        out_mode = {3'd2, 3'd4}; step(2'b11, 1, 1);
        cap_mode = 2'b11; out_mode = 6'o00; sw_level = 2'b10; step(2'b11, 1, 1);
        cap_mode = 0;
        // Random mix of all modes and events
        for (int k = 0; k < 4000; k++) begin
            cnt_dir   = 2'($urandom);
            out_mode  = 6'($urandom);
            pair_mode = 2'($urandom);
            sw_level  = 2'($urandom);
            cap_mode  = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            if (k % 500 == 250) rst_n = 0;
            step(2'($urandom), 1'($urandom), 1'($urandom));
            rst_n = 1;
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule